// File: doc/BRIEF.md
# Parallel RGB Video Timing Monitor

This block sits on a parallel pixel bus that carries 24-bit colour (8 bits each of red, green and blue) with active-low horizontal sync, active-low vertical sync and a blank strobe. Everything runs in the pixel clock domain, nominally 25.175 MHz. The clock itself is used only as the clock. Every other input goes through one register stage. The registered values are forwarded unchanged to a downstream consumer such as a display encoder.

Beside the forwarding path, the block rebuilds the line and frame structure of the stream. It measures four segments on each axis: active region, front porch (blank rising to sync falling), sync pulse and back porch (sync rising to blank falling). It also measures the total period of each axis. Horizontal values are counted in pixel clocks and vertical values in lines. Each value is compared with a parameterised expected profile. The defaults are a 640x480 profile: 640/16/96/48 clocks per line (800 in total) and 480/11/2/32 lines per frame (525 in total).

A mismatch sets a sticky flag for that measurement. A lock output reports when the stream has matched the profile for a run of consecutive full frames.

Top module: `vid_timing_mon`

## Requirements
- R1: Colour, both syncs and blank appear on the outputs exactly one clock after they are presented, with their relative alignment kept. During reset the outputs hold colour 0, both syncs 1 and blank 1.
- R2: On lines that contain active pixels, the horizontal active, front porch, sync and back porch lengths are compared with the profile. A mismatch sets `mismatch_o[0]`, `[1]`, `[2]` or `[3]` respectively.
- R3: The number of clocks between consecutive falling edges of horizontal sync is compared with the profile line total, and a mismatch sets `mismatch_o[4]`.
- R4: Vertical lengths are counted in lines, where a line runs from one horizontal sync fall to the next. A line is active when it holds at least one pixel with blank low, and the vertical sync level of a line is taken at its first clock. Mismatches in vertical active, front porch, sync and back porch set `mismatch_o[5]`, `[6]`, `[7]` and `[8]`. A mismatch in the line count between vertical sync falls sets `mismatch_o[9]`.
- R5: A set mismatch bit stays set while `clr` is low, even if every later frame matches.
- R6: A one-cycle pulse on `clr` clears all mismatch bits on the next clock. A mismatch detected in the same cycle as `clr` still leaves its bit set.
- R7: `locked_o` rises once two consecutive full frames, each bounded by vertical sync falls, finish with no mismatch. It falls on the clock after any mismatch is detected.
- R8: No measurement is compared until its axis has seen a sync falling edge that ends a measured segment. A stream that begins mid-line and mid-frame therefore raises no flag, and `locked_o` stays low until the lock rule is met.
- R9: A back porch that ends in another sync pulse rather than in active video, as on vertical blanking lines, is not compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all mismatch bits |
| pix_rgb_i | input | 24 | Incoming colour word |
| pix_hs_n_i | input | 1 | Incoming horizontal sync, active low |
| pix_vs_n_i | input | 1 | Incoming vertical sync, active low |
| pix_blank_i | input | 1 | Incoming blank strobe, high outside active video |
| pix_rgb_o | output | 24 | Registered colour word |
| pix_hs_n_o | output | 1 | Registered horizontal sync |
| pix_vs_n_o | output | 1 | Registered vertical sync |
| pix_blank_o | output | 1 | Registered blank |
| mismatch_o | output | 10 | Sticky mismatch bits, positions as in R2 to R4 |
| locked_o | output | 1 | Stream matches the profile |

## Verification
The assertions assume the stream changes vertical sync only in the clock where horizontal sync falls. They also assume each line is laid out as sync, back porch, active and front porch, and that pixels arrive every clock with no gaps once streaming starts. The stimulus keeps within these limits: it builds every line from one line generator, starts the run with a partial line and a partial frame, and corrupts one profile field over a whole frame at a time while the stream keeps running. Clear pulses are placed on the first clock of a frame.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACT,
    PH_FP,
    PH_SYNC,
    PH_BP
  } phase_e;

  localparam int SEG_ACT = 0;
  localparam int SEG_FP  = 1;
  localparam int SEG_SYN = 2;
  localparam int SEG_BP  = 3;
  localparam int SEG_TOT = 4;
  localparam int N_SEG   = 5;
endpackage

// File: rtl/vtm_input_stage.sv
module vtm_input_stage #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rgb_i,
  input  logic          hs_n_i,
  input  logic          vs_n_i,
  input  logic          blank_i,
  output logic [DW-1:0] rgb_q,
  output logic          hs_n_q,
  output logic          vs_n_q,
  output logic          blank_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_q   <= '0;
      hs_n_q  <= 1'b1;
      vs_n_q  <= 1'b1;
      blank_q <= 1'b1;
    end else begin
      rgb_q   <= rgb_i;
      hs_n_q  <= hs_n_i;
      vs_n_q  <= vs_n_i;
      blank_q <= blank_i;
    end
  end

  // R1: idle values on the clock after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (rgb_q == '0 && hs_n_q && vs_n_q && blank_q));
endmodule

// File: rtl/vtm_line_sampler.sv
module vtm_line_sampler (
  input  logic clk,
  input  logic rst,
  input  logic hs_n,
  input  logic vs_n,
  input  logic blank,
  output logic line_tick,
  output logic line_blank,
  output logic line_vs_n
);
  logic hs_d;
  logic had_act_q;
  logic vs_line_q;

  assign line_tick  = hs_d & ~hs_n;
  assign line_blank = ~had_act_q;
  assign line_vs_n  = vs_line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d      <= 1'b1;
      had_act_q <= 1'b0;
      vs_line_q <= 1'b1;
    end else begin
      hs_d <= hs_n;
      if (line_tick) begin
        had_act_q <= ~blank;
        vs_line_q <= vs_n;
      end else if (!blank) begin
        had_act_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtm_axis_meter.sv
module vtm_axis_meter
  import vtm_pkg::*;
#(
  parameter int ACT  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int BP   = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             blank_i,
  input  logic             sync_n_i,
  output logic [N_SEG-1:0] err_o,
  output logic             frame_o,
  output logic             complete_o
);
  localparam int TOT = ACT + FP + SYNC + BP;
  localparam int CW  = $clog2(TOT + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  phase_e          phase_q, ph_nxt;
  logic [CW-1:0]   run_q, tot_q, exp_run;
  logic            primed_q, change, enter_sync, cmp_seg;
  logic [N_SEG-1:0] err_d;

  always_comb begin
    if (!sync_n_i)                             ph_nxt = PH_SYNC;
    else if (!blank_i)                         ph_nxt = PH_ACT;
    else if (phase_q == PH_ACT || phase_q == PH_FP) ph_nxt = PH_FP;
    else                                       ph_nxt = PH_BP;
  end

  assign change     = tick && (ph_nxt != phase_q);
  assign enter_sync = change && (ph_nxt == PH_SYNC) && (phase_q != PH_IDLE);
  assign cmp_seg    = change && primed_q && (phase_q != PH_IDLE) &&
                      !(phase_q == PH_BP && ph_nxt != PH_ACT);

  always_comb begin
    case (phase_q)
      PH_ACT:  exp_run = CW'(ACT);
      PH_FP:   exp_run = CW'(FP);
      PH_SYNC: exp_run = CW'(SYNC);
      PH_BP:   exp_run = CW'(BP);
      default: exp_run = '0;
    endcase
  end

  always_comb begin
    err_d = '0;
    if (cmp_seg && run_q != exp_run) begin
      case (phase_q)
        PH_ACT:  err_d[SEG_ACT] = 1'b1;
        PH_FP:   err_d[SEG_FP]  = 1'b1;
        PH_SYNC: err_d[SEG_SYN] = 1'b1;
        PH_BP:   err_d[SEG_BP]  = 1'b1;
        default: err_d = '0;
      endcase
    end
    err_d[SEG_TOT] = enter_sync && primed_q && (tot_q != CW'(TOT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      run_q      <= '0;
      tot_q      <= '0;
      primed_q   <= 1'b0;
      err_o      <= '0;
      frame_o    <= 1'b0;
      complete_o <= 1'b0;
    end else begin
      err_o      <= err_d;
      frame_o    <= enter_sync;
      complete_o <= enter_sync && primed_q;
      if (tick) begin
        phase_q <= ph_nxt;
        if (change)            run_q <= CW'(1);
        else if (run_q != CMAX) run_q <= run_q + 1'b1;
        if (change && ph_nxt == PH_SYNC) tot_q <= CW'(1);
        else if (tot_q != CMAX)          tot_q <= tot_q + 1'b1;
        if (enter_sync) primed_q <= 1'b1;
      end
    end
  end

  // R8: a completed-frame report needs an earlier measured sync fall
  a_r8_complete_needs_frame: assert property (@(posedge clk) disable iff (rst)
    complete_o |-> frame_o);
endmodule

// File: rtl/vid_timing_mon.sv
module vid_timing_mon
  import vtm_pkg::*;
#(
  parameter int COLOR_W     = 8,
  parameter int H_ACT       = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_ACT       = 480,
  parameter int V_FP        = 11,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 32,
  parameter int LOCK_FRAMES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic [3*COLOR_W-1:0] pix_rgb_i,
  input  logic                 pix_hs_n_i,
  input  logic                 pix_vs_n_i,
  input  logic                 pix_blank_i,
  output logic [3*COLOR_W-1:0] pix_rgb_o,
  output logic                 pix_hs_n_o,
  output logic                 pix_vs_n_o,
  output logic                 pix_blank_o,
  output logic [2*N_SEG-1:0]   mismatch_o,
  output logic                 locked_o
);
  localparam int DW  = 3 * COLOR_W;
  localparam int NF  = 2 * N_SEG;
  localparam int LCW = $clog2(LOCK_FRAMES + 1);
  localparam logic [LCW-1:0] LMAX = LCW'(LOCK_FRAMES);

  logic [N_SEG-1:0] h_err, v_err;
  logic [NF-1:0]    new_err;
  logic             h_frame_unused, h_complete_unused;
  logic             v_frame, v_complete;
  logic             ln_tick, ln_blank, ln_vs_n;
  logic             any_err, dirty_q;
  logic [LCW-1:0]   clean_q, clean_inc;

  vtm_input_stage #(.DW(DW)) u_in (
    .clk(clk), .rst(rst),
    .rgb_i(pix_rgb_i), .hs_n_i(pix_hs_n_i), .vs_n_i(pix_vs_n_i), .blank_i(pix_blank_i),
    .rgb_q(pix_rgb_o), .hs_n_q(pix_hs_n_o), .vs_n_q(pix_vs_n_o), .blank_q(pix_blank_o)
  );

  vtm_axis_meter #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_h (
    .clk(clk), .rst(rst), .tick(1'b1),
    .blank_i(pix_blank_o), .sync_n_i(pix_hs_n_o),
    .err_o(h_err), .frame_o(h_frame_unused), .complete_o(h_complete_unused)
  );

  vtm_line_sampler u_ls (
    .clk(clk), .rst(rst),
    .hs_n(pix_hs_n_o), .vs_n(pix_vs_n_o), .blank(pix_blank_o),
    .line_tick(ln_tick), .line_blank(ln_blank), .line_vs_n(ln_vs_n)
  );

  vtm_axis_meter #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_v (
    .clk(clk), .rst(rst), .tick(ln_tick),
    .blank_i(ln_blank), .sync_n_i(ln_vs_n),
    .err_o(v_err), .frame_o(v_frame), .complete_o(v_complete)
  );

  assign new_err   = {v_err, h_err};
  assign any_err   = |new_err;
  assign clean_inc = (clean_q == LMAX) ? LMAX : clean_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch_o <= '0;
      locked_o   <= 1'b0;
      dirty_q    <= 1'b0;
      clean_q    <= '0;
    end else begin
      mismatch_o <= (clr ? '0 : mismatch_o) | new_err;
      if (any_err) begin
        locked_o <= 1'b0;
        clean_q  <= '0;
        dirty_q  <= !v_frame;
      end else if (v_frame) begin
        dirty_q <= 1'b0;
        if (v_complete && !dirty_q) begin
          clean_q  <= clean_inc;
          locked_o <= (clean_inc == LMAX);
        end else begin
          clean_q  <= '0;
          locked_o <= 1'b0;
        end
      end
    end
  end

  // R5: bits never fall without a clear
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((mismatch_o & $past(mismatch_o)) == $past(mismatch_o)));
  // R6: clear empties the flags when nothing new arrives
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && new_err == '0) |=> (mismatch_o == '0));
  // R6: a new mismatch is always recorded, clear or not
  a_r6_new_wins: assert property (@(posedge clk) disable iff (rst)
    (new_err != '0) |=> ((mismatch_o & $past(new_err)) == $past(new_err)));
  // R7: any mismatch drops lock
  a_r7_unlock: assert property (@(posedge clk) disable iff (rst)
    any_err |=> !locked_o);
  // R7: lock only rises at a frame boundary
  a_r7_lock_at_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(v_frame));
endmodule

// File: tb/tb_vid_timing_mon.sv
module tb_vid_timing_mon;
  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 4, VF = 3, VS = 2, VB = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [23:0] rgb_i = '0;
  logic        hs_i = 1'b1, vs_i = 1'b1, bl_i = 1'b1;
  logic [23:0] rgb_o;
  logic        hs_o, vs_o, bl_o, locked;
  logic [9:0]  mism;

  int n_chk = 0, n_fail = 0;
  logic        clr_req = 1'b0;
  logic [23:0] pat = 24'h13579B;
  logic [26:0] sb[$];

  always #4 clk = ~clk;

  vid_timing_mon #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut (
    .clk(clk), .rst(rst), .clr(clr),
    .pix_rgb_i(rgb_i), .pix_hs_n_i(hs_i), .pix_vs_n_i(vs_i), .pix_blank_i(bl_i),
    .pix_rgb_o(rgb_o), .pix_hs_n_o(hs_o), .pix_vs_n_o(vs_o), .pix_blank_o(bl_o),
    .mismatch_o(mism), .locked_o(locked)
  );

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: R1 one-cycle passthrough scoreboard
  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      logic [26:0] e, g;
      e = sb.pop_front();
      g = {rgb_o, hs_o, vs_o, bl_o};
      n_chk++;
      if (g !== e) begin
        n_fail++;
        $display("FAIL R1 passthrough got %h expected %h", g, e);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got running expected done");
    finish_up();
  end

  task automatic drive_vec(input logic h, input logic v, input logic b);
    @(negedge clk);
    pat   = pat * 24'd5 + 24'h1F3D5B;
    rgb_i = pat;
    hs_i  = h;
    vs_i  = v;
    bl_i  = b;
    clr   = clr_req;
    clr_req = 1'b0;
    sb.push_back({pat, h, v, b});
  endtask

  task automatic gen_frame(input int ha, input int hf, input int hs, input int hb,
                           input int va, input int vf, input int vs, input int vb,
                           input int first_line);
    int tot_l = hs + hb + ha + hf;
    int tot_f = vs + vb + va + vf;
    for (int ln = first_line; ln < tot_f; ln++) begin
      logic act_line = (ln >= vs + vb) && (ln < vs + vb + va);
      for (int c = 0; c < tot_l; c++) begin
        logic act_px = act_line && (c >= hs + hb) && (c < hs + hb + ha);
        drive_vec(!(c < hs), !(ln < vs), !act_px);
      end
    end
  endtask

  task automatic good_frame();
    gen_frame(HA, HF, HS, HB, VA, VF, VS, VB, 0);
  endtask

  task automatic check_state(input logic [9:0] ef, input logic el, input string tag);
    n_chk++;
    if (mism !== ef) begin
      n_fail++;
      $display("FAIL %s mismatch got %b expected %b", tag, mism, ef);
    end
    n_chk++;
    if (locked !== el) begin
      n_fail++;
      $display("FAIL %s locked got %b expected %b", tag, locked, el);
    end
  endtask

  task automatic scenario(input int ha, input int hf, input int hs, input int hb,
                          input int va, input int vf, input int vs, input int vb,
                          input logic [9:0] ef, input string tag);
    gen_frame(ha, hf, hs, hb, va, vf, vs, vb, 0);
    good_frame();
    good_frame();
    // R5: flags survive two clean frames; R7: lock lost and not yet regained
    check_state(ef, 1'b0, {tag, " R5 R7"});
    clr_req = 1'b1;
    good_frame();
    // R6: clear empties flags; R7: two clean frames relock
    check_state(10'b0, 1'b1, {tag, " R6 R7"});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if ({rgb_o, hs_o, vs_o, bl_o} !== {24'h0, 1'b1, 1'b1, 1'b1}) begin
      n_fail++;
      $display("FAIL R1 reset outputs got %h expected %h",
               {rgb_o, hs_o, vs_o, bl_o}, {24'h0, 3'b111});
    end
    check_state(10'b0, 1'b0, "R8 reset");
    rst = 1'b0;
    @(negedge clk);

    // R8: start mid-line and mid-frame
    for (int i = 0; i < 5; i++) drive_vec(1'b1, 1'b1, 1'b0);
    gen_frame(HA, HF, HS, HB, VA, VF, VS, VB, VS + VB + VA - 2);
    check_state(10'b0, 1'b0, "R8 partial start");
    good_frame();
    good_frame();
    check_state(10'b0, 1'b0, "R7 one clean frame");
    good_frame();
    // R9: blank lines with long back porch raise nothing
    check_state(10'b0, 1'b1, "R7 R9 locked clean");

    // R2 / R3 horizontal faults
    scenario(HA - 1, HF, HS, HB, VA, VF, VS, VB, 10'b00000_10001, "R2 R3 h active");
    scenario(HA, HF + 1, HS, HB, VA, VF, VS, VB, 10'b00000_10010, "R2 R3 h front porch");
    scenario(HA, HF, HS + 1, HB, VA, VF, VS, VB, 10'b00000_10100, "R2 R3 h sync");
    scenario(HA, HF, HS, HB - 1, VA, VF, VS, VB, 10'b00000_11000, "R2 R3 h back porch");
    // R4 vertical faults
    scenario(HA, HF, HS, HB, VA - 1, VF, VS, VB, 10'b10001_00000, "R4 v active");
    scenario(HA, HF, HS, HB, VA, VF + 2, VS, VB, 10'b10010_00000, "R4 v front porch");
    scenario(HA, HF, HS, HB, VA, VF, VS + 1, VB, 10'b10100_00000, "R4 v sync");
    scenario(HA, HF, HS, HB, VA, VF, VS, VB - 1, 10'b11000_00000, "R4 v back porch");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule